// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Flow-Control Output

This block turns an asynchronous 8N1 serial line into bytes. A baud-rate enable (`tick_i`) pulses for one clock at sixteen times the bit rate. While the line is idle, the receiver watches for a high-to-low transition, which marks a start bit. It then counts eight ticks to reach the middle of the start bit and fixes that phase for the rest of the frame. From that point it samples eight data bits, least significant bit first, and one stop bit, one every sixteen ticks.

Good characters go into a 32-entry receive queue. A valid/ready port drains the queue in arrival order. An active-low request-to-send output tells the far end to pause while the queue has four or fewer free slots. A character with a low stop bit raises a one-cycle framing-error pulse and is dropped. A character that arrives while the queue is full is also dropped, and it sets an overrun flag that stays set until reset.

Top module: `uart_rx_fc`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_valid_o`, `rts_n_o`, `frame_err_o` and `overrun_o` are all 0.
- R2: In the idle state, a falling edge seen between two ticks starts a frame. If the line is high again at the 8th tick after the edge, the event is treated as a glitch: no character is produced, no error is flagged, and the receiver waits for the next falling edge.
- R3: After the start-bit centre, eight data bits are sampled 16 ticks apart. The first data bit is bit 0 of the character.
- R4: The stop bit is sampled 16 ticks after the last data bit. When it is 1, the character is written to the queue and appears on `rd_data_o` with `rd_valid_o` high.
- R5: When the stop bit is 0, `frame_err_o` is high for exactly one clock cycle and the character is not stored.
- R6: The queue holds up to 32 characters and returns them in the order they arrived.
- R7: An entry is removed only in a cycle where `rd_valid_o` and `rd_ready_i` are both high. While `rd_ready_i` is low, `rd_valid_o` and `rd_data_o` hold their values.
- R8: `rts_n_o` is 1 (stop sending) while the queue has four or fewer free slots, that is, while it holds 28 or more characters. It is 0 while more than four slots are free.
- R9: A character completed while the queue holds 32 entries is discarded. It sets `overrun_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle enable at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idles high |
| rd_data_o | output | 8 | Oldest stored character |
| rd_valid_o | output | 1 | Queue is not empty |
| rd_ready_i | input | 1 | Consumer takes `rd_data_o` this cycle |
| rts_n_o | output | 1 | Active-low request-to-send; 1 asks the far end to pause |
| frame_err_o | output | 1 | One-cycle pulse on a low stop bit |
| overrun_o | output | 1 | Sticky flag: a character was lost to a full queue |

## Verification
The properties assume that `rd_ready_i` changes only at clock edges. They also assume that `tick_i` is a single-cycle pulse spaced far enough apart that the receiver state advances at most once per tick. The stimulus spaces ticks four clocks apart. It holds each serial bit for exactly sixteen tick periods and returns the line high between frames, so every sample point falls well inside its bit. The bench changes the ready input only just after a clock edge, and it never completes a character in the same cycle as a read from a full queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Result of one completed frame, handed from the sampler to the queue.
  typedef struct packed {
    logic       good;
    logic       bad;
    logic [7:0] data;
  } rx_result_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial line; resets to idle (1).
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Frame sampler: finds the start edge, locks the bit centre, shifts in data.
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              push_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W    = $clog2(OSR);
  localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              prev_q;
  rx_result_t        res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      prev_q  <= 1'b1;
      res_q   <= '0;
    end else begin
      res_q.good <= 1'b0;
      res_q.bad  <= 1'b0;
      if (tick_i) begin
        prev_q <= line_i;
        unique case (state_q)
          RX_IDLE: begin
            if (prev_q && !line_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == HALF_LAST) begin
              cnt_q <= '0;
              idx_q <= '0;
              // high at the centre: a glitch, not a start bit
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q   <= '0;
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) state_q <= RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q      <= '0;
              state_q    <= RX_IDLE;
              res_q.data <= shift_q;
              res_q.good <= line_i;
              res_q.bad  <= !line_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign push_o = res_q.good;
  assign ferr_o = res_q.bad;
  assign data_o = res_q.data[DATA_W-1:0];
endmodule

// File: rtl/uart_rx_fifo.sv
// Receive queue: simple dual-port storage, show-ahead read, level tracking.
module uart_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      pop_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      full_o,
  output logic [$clog2(DEPTH+1)-1:0] level_nxt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]     level_q, level_d;
  logic              do_wr, do_rd;

  assign full_o = (level_q == LVL_FULL);
  assign do_wr  = push_i && !full_o;
  assign do_rd  = pop_i && (level_q != '0);

  always_comb begin
    level_d = level_q;
    if (do_wr && !do_rd)      level_d = level_q + 1'b1;
    else if (!do_wr && do_rd) level_d = level_q - 1'b1;
  end

  // storage write port without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      level_q <= level_d;
      if (do_wr) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  assign rdata_o     = mem[rd_ptr_q];
  assign level_nxt_o = level_d;
endmodule

// File: rtl/uart_rx_fc.sv
// Top: synchronizer, frame sampler, receive queue, flow-control and flags.
module uart_rx_fc #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int DEPTH       = 32,
  parameter int FREE_LIMIT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              rts_n_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  localparam int LW        = $clog2(DEPTH+1);
  localparam int PAUSE_LVL = DEPTH - FREE_LIMIT;

  logic              line_s;
  logic              push, ferr, full, pop;
  logic [DATA_W-1:0] push_data;
  logic [LW-1:0]     level_nxt;
  logic              valid_q, rts_n_q, ovr_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (line_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .line_i (line_s),
    .push_o (push),
    .ferr_o (ferr),
    .data_o (push_data)
  );

  assign pop = valid_q && rd_ready_i;

  uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push),
    .wdata_i     (push_data),
    .pop_i       (pop),
    .rdata_o     (rd_data_o),
    .full_o      (full),
    .level_nxt_o (level_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rts_n_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= (level_nxt != '0);
      rts_n_q <= (int'(level_nxt) >= PAUSE_LVL);
      if (push && full) ovr_q <= 1'b1;
    end
  end

  assign rd_valid_o  = valid_q;
  assign rts_n_o     = rts_n_q;
  assign frame_err_o = ferr;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic              rts_n_o,
  input logic              frame_err_o,
  input logic              overrun_o
);
  // R5
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  // R8
  pause_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    rts_n_o |-> rd_valid_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid_o && !rts_n_o && !overrun_o && !frame_err_o));
endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rts_n_o     (rts_n_o),
  .frame_err_o (frame_err_o),
  .overrun_o   (overrun_o)
);

// File: tb/sim_uart_rx_fc.sv
`timescale 1ns/1ps
module sim_uart_rx_fc;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       rd_ready_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o, rts_n_o, frame_err_o, overrun_o;

  int n_run = 0;
  int n_fail = 0;
  int ferr_seen = 0;
  bit done = 1'b0;

  uart_rx_fc u0 (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .rxd_i       (rxd_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rts_n_o     (rts_n_o),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o)
  );

  initial forever #2.5 clk = ~clk;

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      tick_i = (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (!rst && frame_err_o) ferr_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd_i = b;
    repeat (BIT_CLKS) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] v, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(stop);
    send_bit(1'b1);
  endtask

  task automatic read_one(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rd_valid_o == 1'b1, req, rd_valid_o, 1);
    chk(rd_data_o == exp, req, rd_data_o, exp);
    @(posedge clk); #1;
    rd_ready_i = 1'b1;
    @(posedge clk); #1;
    rd_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!rd_valid_o && !rts_n_o && !frame_err_o && !overrun_o, "R1",
        {rd_valid_o, rts_n_o, frame_err_o, overrun_o}, 0);
  endtask

  task automatic t_basic;
    send_frame(8'hA5, 1'b1);
    read_one(8'hA5, "R3/R4 0xA5");
    send_frame(8'h01, 1'b1);
    read_one(8'h01, "R3 lsb first");
    send_frame(8'h80, 1'b1);
    read_one(8'h80, "R3 msb last");
    send_frame(8'h00, 1'b1);
    read_one(8'h00, "R4 zeros");
    send_frame(8'hFF, 1'b1);
    read_one(8'hFF, "R4 ones");
    @(negedge clk);
    chk(!rd_valid_o, "R4 empty after reads", rd_valid_o, 0);
  endtask

  task automatic t_glitch;
    int f0;
    f0 = ferr_seen;
    rxd_i = 1'b0;
    repeat (4 * TICK_DIV) @(posedge clk);
    #1;
    rxd_i = 1'b1;
    repeat (3 * BIT_CLKS) @(posedge clk);
    @(negedge clk);
    chk(!rd_valid_o, "R2 glitch no data", rd_valid_o, 0);
    chk(ferr_seen == f0, "R2 glitch no error", ferr_seen - f0, 0);
    send_frame(8'h3C, 1'b1);
    read_one(8'h3C, "R2 frame after glitch");
  endtask

  task automatic t_frame_err;
    int f0;
    f0 = ferr_seen;
    send_frame(8'h5A, 1'b0);
    send_bit(1'b1);
    @(negedge clk);
    chk(ferr_seen == f0 + 1, "R5 one pulse", ferr_seen - f0, 1);
    chk(!rd_valid_o, "R5 discarded", rd_valid_o, 0);
    send_frame(8'hC3, 1'b1);
    read_one(8'hC3, "R5 recovers");
  endtask

  task automatic t_hold;
    logic [7:0] d0;
    send_frame(8'h96, 1'b1);
    @(negedge clk);
    d0 = rd_data_o;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(rd_valid_o && rd_data_o == 8'h96 && d0 == 8'h96, "R7 hold without ready",
        rd_data_o, 8'h96);
    read_one(8'h96, "R7 pop");
    @(negedge clk);
    chk(!rd_valid_o, "R7 single pop", rd_valid_o, 0);
  endtask

  task automatic t_fill;
    for (int k = 0; k < 33; k++) begin
      send_frame(8'h40 + 8'(k), 1'b1);
      @(negedge clk);
      if (k == 26) chk(rts_n_o == 1'b0, "R8 27 stored runs", rts_n_o, 0);
      if (k == 27) chk(rts_n_o == 1'b1, "R8 28 stored pauses", rts_n_o, 1);
      if (k == 31) chk(overrun_o == 1'b0, "R6 32 fit", overrun_o, 0);
      if (k == 32) chk(overrun_o == 1'b1, "R9 overrun set", overrun_o, 1);
    end
    for (int i = 0; i < 32; i++) begin
      read_one(8'h40 + 8'(i), "R6 order");
      @(negedge clk);
      if (i == 3) chk(rts_n_o == 1'b1, "R8 28 left pauses", rts_n_o, 1);
      if (i == 4) chk(rts_n_o == 1'b0, "R8 27 left resumes", rts_n_o, 0);
    end
    @(negedge clk);
    chk(!rd_valid_o, "R9 dropped char absent", rd_valid_o, 0);
    chk(overrun_o, "R9 sticky", overrun_o, 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    repeat (2 * BIT_CLKS) @(posedge clk);
    #1;
    t_basic();
    t_glitch();
    t_frame_err();
    t_hold();
    t_fill();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule